// File: doc/BRIEF.md
# Sync Character Hunt Receiver

This block is the front end of a byte-oriented synchronous receiver. Serial data arrives one bit per cycle on which the receive clock enable is high. After reset or a resync command, the receiver hunts. It compares the most recent bits against a programmable sync pattern of 2 to 16 bits. When the pattern completes, it reports that sync was found and starts framing. From then on it assembles characters of 1 to 8 bits and presents each one with a one-cycle valid pulse.

In external-sync mode the receiver does not look for a pattern. It waits for a strobe on a dedicated input and starts framing from that strobe. Driving this strobe from the transmitter's own character-boundary signal slaves the receiver to the transmitter, so both sides share one character framing. An optional strip setting discards characters that complete the sync pattern, so idle fill does not reach the data path.

The controller is built around three states:
- `ST_HUNT`: pattern search.
- `ST_EXT_WAIT`: waiting for the external strobe.
- `ST_FRAME`: character assembly.

Its transitions are:
- `ST_HUNT` to `ST_FRAME` on a pattern match.
- `ST_HUNT` to `ST_EXT_WAIT` when external mode is selected.
- `ST_EXT_WAIT` to `ST_HUNT` when external mode is deselected.
- `ST_EXT_WAIT` to `ST_FRAME` on the external strobe.
- Any state to `ST_HUNT` or `ST_EXT_WAIT` on a resync command. The mode input decides which of the two.

Top module: `sync_hunt_rx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `in_frame_o`, `sync_found_o` and `char_valid_o` are 0 and `char_data_o` is all zeros.
- R2: In pattern mode, bits are shifted MSB-first. The first bit of the pattern received is compared with bit N-1 of `sync_pat_i`, where N is the effective sync length, and pattern bits at N and above are ignored. One cycle after the enabled bit that completes the pattern, `sync_found_o` pulses for one cycle and `in_frame_o` rises in that same cycle. `in_frame_o` never rises without a `sync_found_o` pulse.
- R3: After reset or a resync, no match is accepted until at least N enabled bits have been received. This holds even if the cleared shift register already equals the pattern.
- R4: `sync_len_i` values below 2 act as 2 and values above 16 act as 16. `char_len_i` values below 1 act as 1 and values above 8 act as 8.
- R5: Once framing, every L enabled bits (L being the effective character length) produce a one-cycle `char_valid_o` pulse, one cycle after the last bit. `char_data_o` holds those L bits right-justified: the first-received bit is in bit L-1 and the upper bits are 0. The sync pattern that started framing is never delivered. `char_valid_o` is only ever high while framing.
- R6: Only cycles with `rx_en_i` high carry a bit. Gaps of any length between bits do not change the assembled characters, and `char_valid_o` is 0 in the cycle after a cycle with `rx_en_i` low.
- R7: With `strip_i` low, a character equal to the sync pattern is delivered as data. With `strip_i` high, a character at whose last bit the latest N bits equal the pattern is dropped.
- R8: A `hunt_i` pulse has priority over every other input. In the next cycle `in_frame_o`, `sync_found_o` and `char_valid_o` are 0, the bit presented with it is discarded, and the shift register and bit history are cleared.
- R9: In external mode, pattern matches are ignored. A high `ext_sync_i` while waiting gives a `sync_found_o` pulse and framing one cycle later. The first character starts with the first enabled bit after the strobe cycle.
- R10: While framing, `ext_sync_i` and pattern matches have no effect: framing continues and `sync_found_o` stays 0.
- R11: `char_data_o` keeps its value in every cycle in which `char_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en_i | input | 1 | Receive bit enable; one bit per high cycle |
| rx_bit_i | input | 1 | Serial receive data |
| sync_pat_i | input | 16 | Sync pattern; the low N bits are used |
| sync_len_i | input | 5 | Sync length N, 2 to 16 |
| char_len_i | input | 4 | Character length L, 1 to 8 |
| ext_mode_i | input | 1 | Selects external-strobe framing |
| ext_sync_i | input | 1 | External framing strobe |
| strip_i | input | 1 | Drop characters that complete the sync pattern |
| hunt_i | input | 1 | Resync command |
| in_frame_o | output | 1 | Receiver is assembling characters |
| sync_found_o | output | 1 | One-cycle pulse on framing start |
| char_valid_o | output | 1 | One-cycle pulse with a new character |
| char_data_o | output | 8 | Last assembled character, right-justified |

## Verification
The assertions assume the configuration inputs (pattern, lengths, mode and strip) stay constant while framing, and that `hunt_i` is a single-cycle command. The stimulus changes configuration only in the cycle of a resync or while idle in hunt, and it raises `hunt_i` for exactly one cycle. `ext_sync_i` is pulsed both while waiting and in the middle of a character. Sync patterns are preceded by prefix bits chosen so that no earlier window matches the pattern.

// File: rtl/synh_pkg.sv
package synh_pkg;

    typedef enum logic [1:0] {
        ST_HUNT     = 2'd0,
        ST_EXT_WAIT = 2'd1,
        ST_FRAME    = 2'd2
    } synh_state_e;

    // Bounds a programmed length to the legal range.
    function automatic int clamp_len(int v, int lo, int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/synh_shift.sv
// Serial shift register (newest bit in bit 0) plus a saturating count of
// bits received since the last clear.
module synh_shift #(
    parameter int W      = 16,
    parameter int FILL_W = $clog2(W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic [W-1:0]      sr_next,
    output logic [FILL_W-1:0] fill_next
);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(W);

    logic [W-1:0]      sr_q;
    logic [FILL_W-1:0] fill_q;

    always_comb begin
        sr_next   = sr_q;
        fill_next = fill_q;
        if (clr) begin
            sr_next   = '0;
            fill_next = '0;
        end else if (bit_en) begin
            sr_next = {sr_q[W-2:0], bit_in};
            if (fill_q != FILL_MAX) fill_next = fill_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            fill_q <= '0;
        end else begin
            sr_q   <= sr_next;
            fill_q <= fill_next;
        end
    end
endmodule

// File: rtl/synh_match.sv
// Masked comparison of the newest N bits against the pattern, qualified by
// enough bits of history.
module synh_match #(
    parameter int W     = 16,
    parameter int LEN_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     word,
    input  logic [W-1:0]     pattern,
    input  logic [LEN_W-1:0] len,
    input  logic [LEN_W-1:0] fill,
    output logic             hit
);
    import synh_pkg::*;

    logic [LEN_W-1:0] eff_len;
    logic [W-1:0]     mask;

    assign eff_len = LEN_W'(clamp_len(int'(len), 2, W));

    for (genvar gi = 0; gi < W; gi++) begin : g_mask
        assign mask[gi] = (eff_len > LEN_W'(gi));
    end

    assign hit = (((word ^ pattern) & mask) == '0) && (fill >= eff_len);
endmodule

// File: rtl/synh_bitcnt.sv
// Counts enabled bits inside a character and flags the last one.
module synh_bitcnt #(
    parameter int CHAR_W = 8,
    parameter int LEN_W  = $clog2(CHAR_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bit_en,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] eff_len,
    output logic             done
);
    import synh_pkg::*;

    logic [LEN_W-1:0] cnt_q, cnt_d, cnt_inc;

    assign eff_len = LEN_W'(clamp_len(int'(len), 1, CHAR_W));
    assign cnt_inc = cnt_q + 1'b1;
    assign done    = !clr && bit_en && (cnt_inc >= eff_len);

    always_comb begin
        cnt_d = cnt_q;
        if (clr)         cnt_d = '0;
        else if (done)   cnt_d = '0;
        else if (bit_en) cnt_d = cnt_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sync_hunt_rx.sv
// Byte-oriented synchronous receiver front end: pattern hunt, external
// strobe framing and character assembly. CHAR_W must not exceed SYNC_W.
module sync_hunt_rx #(
    parameter int SYNC_W = 16,
    parameter int CHAR_W = 8,
    parameter int SLEN_W = $clog2(SYNC_W + 1),
    parameter int CLEN_W = $clog2(CHAR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en_i,
    input  logic              rx_bit_i,
    input  logic [SYNC_W-1:0] sync_pat_i,
    input  logic [SLEN_W-1:0] sync_len_i,
    input  logic [CLEN_W-1:0] char_len_i,
    input  logic              ext_mode_i,
    input  logic              ext_sync_i,
    input  logic              strip_i,
    input  logic              hunt_i,
    output logic              in_frame_o,
    output logic              sync_found_o,
    output logic              char_valid_o,
    output logic [CHAR_W-1:0] char_data_o
);
    import synh_pkg::*;

    synh_state_e state_q, state_d;

    logic [SYNC_W-1:0] sr_next;
    logic [SLEN_W-1:0] fill_next;
    logic              hit;
    logic              cnt_clr;
    logic              char_done;
    logic [CLEN_W-1:0] eff_clen;
    logic [CHAR_W-1:0] char_word;
    logic              pat_found;
    logic              ext_found;
    logic              emit;

    synh_shift #(.W(SYNC_W), .FILL_W(SLEN_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (hunt_i),
        .bit_en   (rx_en_i),
        .bit_in   (rx_bit_i),
        .sr_next  (sr_next),
        .fill_next(fill_next)
    );

    synh_match #(.W(SYNC_W), .LEN_W(SLEN_W)) u_match (
        .word   (sr_next),
        .pattern(sync_pat_i),
        .len    (sync_len_i),
        .fill   (fill_next),
        .hit    (hit)
    );

    assign cnt_clr = hunt_i || (state_q != ST_FRAME);

    synh_bitcnt #(.CHAR_W(CHAR_W), .LEN_W(CLEN_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .bit_en (rx_en_i),
        .len    (char_len_i),
        .eff_len(eff_clen),
        .done   (char_done)
    );

    // Right-justified character: the low L bits of the shift register.
    for (genvar gi = 0; gi < CHAR_W; gi++) begin : g_char
        assign char_word[gi] = (eff_clen > CLEN_W'(gi)) ? sr_next[gi] : 1'b0;
    end

    assign pat_found = (state_q == ST_HUNT) && !ext_mode_i && rx_en_i && hit;
    assign ext_found = (state_q == ST_EXT_WAIT) && ext_mode_i && ext_sync_i;
    assign emit      = (state_q == ST_FRAME) && char_done && !(strip_i && hit);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (hunt_i) begin
            state_d = ext_mode_i ? ST_EXT_WAIT : ST_HUNT;
        end else begin
            unique case (state_q)
                ST_HUNT: begin
                    if (ext_mode_i)     state_d = ST_EXT_WAIT;
                    else if (pat_found) state_d = ST_FRAME;
                end
                ST_EXT_WAIT: begin
                    if (!ext_mode_i)    state_d = ST_HUNT;
                    else if (ext_found) state_d = ST_FRAME;
                end
                ST_FRAME: state_d = ST_FRAME;
                default:  state_d = ST_HUNT;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_found_o <= 1'b0;
            char_valid_o <= 1'b0;
            char_data_o  <= '0;
        end else begin
            sync_found_o <= !hunt_i && (pat_found || ext_found);
            char_valid_o <= !hunt_i && emit;
            if (!hunt_i && emit) char_data_o <= char_word;
        end
    end

    assign in_frame_o = (state_q == ST_FRAME);

endmodule

// File: rtl/synh_checker.sv
module synh_checker #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en_i,
    input logic              ext_mode_i,
    input logic              ext_sync_i,
    input logic              hunt_i,
    input logic              in_frame_o,
    input logic              sync_found_o,
    input logic              char_valid_o,
    input logic [CHAR_W-1:0] char_data_o
);
    assert_found_enters_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_found_o |-> (in_frame_o && !$past(in_frame_o)));

    assert_frame_entry_found_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame_o) |-> sync_found_o);

    assert_char_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid_o |-> (in_frame_o && $past(in_frame_o)));

    assert_no_bit_no_char_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_i |=> !char_valid_o);

    assert_hunt_leaves_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_i |=> (!in_frame_o && !char_valid_o && !sync_found_o));

    assert_ext_no_pattern_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode_i && !ext_sync_i && !in_frame_o) |=> !sync_found_o);

    assert_frame_ignores_ext_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame_o && !hunt_i) |=> (in_frame_o && !sync_found_o));

    assert_data_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !char_valid_o |-> $stable(char_data_o));
endmodule

bind sync_hunt_rx synh_checker #(.CHAR_W(CHAR_W)) u_synh_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en_i     (rx_en_i),
    .ext_mode_i  (ext_mode_i),
    .ext_sync_i  (ext_sync_i),
    .hunt_i      (hunt_i),
    .in_frame_o  (in_frame_o),
    .sync_found_o(sync_found_o),
    .char_valid_o(char_valid_o),
    .char_data_o (char_data_o)
);

// File: tb/tb_sync_hunt_rx.sv
`timescale 1ns/1ps
module tb_sync_hunt_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en_i = 1'b0;
    logic        rx_bit_i = 1'b0;
    logic [15:0] sync_pat_i = 16'h0016;
    logic [4:0]  sync_len_i = 5'd8;
    logic [3:0]  char_len_i = 4'd8;
    logic        ext_mode_i = 1'b0;
    logic        ext_sync_i = 1'b0;
    logic        strip_i = 1'b0;
    logic        hunt_i = 1'b0;
    logic        in_frame_o;
    logic        sync_found_o;
    logic        char_valid_o;
    logic [7:0]  char_data_o;

    int checks = 0;
    int failures = 0;
    int found_cnt = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    sync_hunt_rx dut (
        .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en_i), .rx_bit_i(rx_bit_i),
        .sync_pat_i(sync_pat_i), .sync_len_i(sync_len_i), .char_len_i(char_len_i),
        .ext_mode_i(ext_mode_i), .ext_sync_i(ext_sync_i), .strip_i(strip_i),
        .hunt_i(hunt_i), .in_frame_o(in_frame_o), .sync_found_o(sync_found_o),
        .char_valid_o(char_valid_o), .char_data_o(char_data_o)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected characters as the design emits them.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (sync_found_o) found_cnt++;
            if (char_valid_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R7", "unexpected char", int'(char_data_o), -1);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(char_data_o == e, "R5", "char data", int'(char_data_o), int'(e));
                end
            end
        end
    end

    task automatic send_bit(bit b);
        @(negedge clk);
        rx_en_i = 1'b1; rx_bit_i = b; hunt_i = 1'b0; ext_sync_i = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            rx_en_i = 1'b0; hunt_i = 1'b0; ext_sync_i = 1'b0;
        end
    endtask

    // Driver: pushes the expected character, then sends it MSB-first.
    task automatic send_char(logic [7:0] v, int len, bit expect_it);
        if (expect_it) exp_q.push_back(v & 8'((1 << len) - 1));
        for (int i = len - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    // Sends a sync pattern, checking no early framing (R3) and the found pulse (R2).
    task automatic send_sync(logic [15:0] p, int len);
        int f0;
        f0 = found_cnt;
        for (int i = len - 1; i >= 0; i--) begin
            @(negedge clk);
            check(!in_frame_o, "R3", "framing before pattern end", int'(in_frame_o), 0);
            rx_en_i = 1'b1; rx_bit_i = p[i]; hunt_i = 1'b0; ext_sync_i = 1'b0;
        end
        @(negedge clk);
        rx_en_i = 1'b0;
        check(sync_found_o, "R2", "sync_found pulse", int'(sync_found_o), 1);
        check(in_frame_o, "R2", "in_frame after match", int'(in_frame_o), 1);
        #1 check(found_cnt == f0 + 1, "R2", "found count", found_cnt, f0 + 1);
    endtask

    task automatic do_hunt();
        @(negedge clk);
        hunt_i = 1'b1; rx_en_i = 1'b1; rx_bit_i = 1'b1; ext_sync_i = 1'b0;
        @(negedge clk);
        hunt_i = 1'b0; rx_en_i = 1'b0;
        check(!in_frame_o, "R8", "in_frame after hunt", int'(in_frame_o), 0);
        check(!sync_found_o && !char_valid_o, "R8", "pulses after hunt",
              int'(sync_found_o) + int'(char_valid_o), 0);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!in_frame_o && !sync_found_o && !char_valid_o && char_data_o == 0,
              "R1", "outputs in reset", int'(in_frame_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!in_frame_o && !char_valid_o && char_data_o == 0,
              "R1", "outputs after reset", int'(char_data_o), 0);

        // R2: 8-bit pattern after noise, then data; R7 strip off delivers sync char
        send_bit(1); send_bit(1); send_bit(1);
        send_sync(16'h0016, 8);
        send_char(8'hA5, 8, 1);
        send_char(8'h3C, 8, 1);
        send_char(8'h16, 8, 1);   // R7: delivered with strip off
        idle(3);
        check(char_data_o == 8'h16, "R11", "data held while idle", int'(char_data_o), 'h16);

        // R7: strip on drops a character equal to the pattern
        strip_i = 1'b1;
        send_char(8'h16, 8, 0);
        send_char(8'h42, 8, 1);
        idle(2);
        strip_i = 1'b0;
        check(exp_q.size() == 0, "R7", "queue drained", exp_q.size(), 0);

        // R6: gaps between bits
        exp_q.push_back(8'hC9);
        for (int i = 7; i >= 0; i--) begin
            send_bit(8'hC9 >> i);
            idle(i % 3);
        end
        idle(2);
        check(exp_q.size() == 0, "R6", "gapped char received", exp_q.size(), 0);

        // R8: hunt mid-character, partial char dropped
        send_bit(1); send_bit(0); send_bit(1);
        do_hunt();
        idle(3);
        check(!in_frame_o, "R8", "stays hunting", int'(in_frame_o), 0);

        // R3: pattern 0000 (len 4, upper pattern bits ignored) after cleared register
        @(negedge clk);
        sync_len_i = 5'd4; sync_pat_i = 16'hFFF0; char_len_i = 4'd5;
        send_sync(16'h0000, 4);
        send_char(8'h13, 5, 1);
        send_char(8'h0A, 5, 1);
        idle(2);

        // R4: lengths clamped (sync 1 -> 2, char 0 -> 1)
        do_hunt();
        sync_len_i = 5'd1; sync_pat_i = 16'h0002; char_len_i = 4'd0;
        send_bit(0);
        idle(1);
        check(!in_frame_o, "R4", "sync length 1 acts as 2", int'(in_frame_o), 0);
        send_sync(16'h0002, 2);
        send_char(8'h01, 1, 1);
        send_char(8'h00, 1, 1);
        send_char(8'h01, 1, 1);
        idle(2);
        check(exp_q.size() == 0, "R4", "one-bit chars", exp_q.size(), 0);

        // R2/R4: 16-bit pattern, 3-bit characters
        do_hunt();
        sync_len_i = 5'd16; sync_pat_i = 16'hB3C4; char_len_i = 4'd3;
        send_bit(0); send_bit(1);
        send_sync(16'hB3C4, 16);
        send_char(8'h05, 3, 1);
        send_char(8'h02, 3, 1);
        idle(2);

        // R9: external mode ignores pattern, frames on strobe
        ext_mode_i = 1'b1;
        do_hunt();
        sync_len_i = 5'd8; sync_pat_i = 16'h0016; char_len_i = 4'd8;
        send_char(8'h16, 8, 0);
        idle(2);
        check(!in_frame_o, "R9", "pattern ignored in ext mode", int'(in_frame_o), 0);
        begin
            int f0;
            f0 = found_cnt;
            @(negedge clk);
            ext_sync_i = 1'b1; rx_en_i = 1'b1; rx_bit_i = 1'b1;
            @(negedge clk);
            ext_sync_i = 1'b0; rx_en_i = 1'b0;
            check(sync_found_o && in_frame_o, "R9", "strobe starts framing",
                  int'(sync_found_o), 1);
            send_char(8'h5A, 8, 1);
            // R10: strobe mid-character has no effect
            exp_q.push_back(8'h3C);
            for (int i = 7; i >= 4; i--) send_bit(8'h3C >> i);
            @(negedge clk);
            rx_en_i = 1'b0; ext_sync_i = 1'b1;
            for (int i = 3; i >= 0; i--) send_bit(8'h3C >> i);
            idle(2);
            #1 check(found_cnt == f0 + 1, "R10", "no extra sync_found", found_cnt, f0 + 1);
            check(in_frame_o, "R10", "still framing", int'(in_frame_o), 1);
        end

        idle(3);
        check(exp_q.size() == 0, "R5", "all characters delivered", exp_q.size(), 0);
        summary();
    end
endmodule